// File: doc/BRIEF.md
# Ethernet PHY Basic Control Register

This block holds the writable control word of a 10/100 Ethernet transceiver as the serial management interface sees it. A management agent reaches it through a plain parallel port: a one-cycle write strobe with a 16-bit word, and a read word that always shows the current register value. The serial framing in front of this port is handled elsewhere. Four fields are implemented: negotiation enable (bit 12), low-power (bit 11), MAC-side isolation (bit 10) and restart-negotiation (bit 9). The other twelve bit positions are reserved.

The low-power and isolation fields act on the MAC-side signals that pass through the block. Low power drives every MAC-facing output low and tri-states the twisted-pair transmitter. Isolation removes the output enable of the MAC-facing pins and blocks the transmit inputs from the PHY core. The isolation default after reset follows a strapped 5-bit PHY address. Restart-negotiation is a self-clearing request. A three-state machine handles it: `AN_IDLE` goes to `AN_REQ` on an accepted request. `AN_REQ` issues a one-cycle start pulse and goes to `AN_WAIT`. `AN_REQ` or `AN_WAIT` returns to `AN_IDLE` when the engine acknowledges, or when negotiation is switched off. On the rising edge of the low-power field, the block emits a one-cycle pulse that returns the latching-high and latching-low status bits held elsewhere to their defaults.

Top module: `phy_ctrl_reg`

## Requirements
- R1: After reset, `rd_data` is 16'h1000 when `phy_addr` is nonzero and 16'h1400 when `phy_addr` is 5'b00000. `isolate_o` matches bit 10 of that value, and `lowpwr_o`, `an_start` and `latch_clr` are 0.
- R2: Bit positions 15..13 and 8..0 always read 0, and writing them has no effect.
- R3: A write stores bits 12, 11 and 10 of `wr_data`. They appear in `rd_data`, and bit 11 on `lowpwr_o` and bit 10 on `isolate_o`, from the clock edge that samples the write.
- R4: A write with both bit 9 and bit 12 set, made while bit 9 reads 0, makes bit 9 read 1 and raises `an_start` for exactly the one cycle after the write.
- R5: While bit 9 reads 1, a cycle with `an_started` high clears bit 9 at the next edge. A further write of 1 to bit 9 during that time starts no new pulse.
- R6: A write with bit 12 clear leaves bit 9 reading 0, including a write that sets bit 9, and no `an_start` pulse follows. The same write also withdraws a pending restart.
- R7: `latch_clr` is high for exactly the one cycle in which `lowpwr_o` has just gone from 0 to 1, and never at any other time.
- R8: While `lowpwr_o` is 1, `tp_tx_tristate` is 1, the MAC-side receive outputs (`mac_rxd_o`, `mac_rxdv_o`, `mac_rxer_o`) are 0, and the transmit signals passed to the core are 0.
- R9: While `isolate_o` is 1, `mac_oe_o` is 0 and `phy_txd_o`, `phy_txen_o` and `phy_txer_o` are 0. While both `isolate_o` and `lowpwr_o` are 0, every MAC-side signal passes through unchanged and `mac_oe_o` is 1.
- R10: Writes and reads behave the same whatever the values of the isolation and low-power fields.
- R11: A write that sets bit 11 changes no other bit apart from what that same write supplies. A pending restart stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phy_addr | input | 5 | Strapped PHY address |
| wr_en | input | 1 | One-cycle register write strobe |
| wr_data | input | 16 | Write word |
| rd_data | output | 16 | Current register value |
| an_start | output | 1 | One-cycle negotiation start pulse |
| an_started | input | 1 | Negotiation engine has started |
| isolate_o | output | 1 | Isolation field |
| lowpwr_o | output | 1 | Low-power field |
| tp_tx_tristate | output | 1 | Twisted-pair transmitter tri-state |
| latch_clr | output | 1 | Clear pulse for latching status bits |
| mac_txd_i | input | 4 | Transmit data from the MAC |
| mac_txen_i | input | 1 | Transmit enable from the MAC |
| mac_txer_i | input | 1 | Transmit error from the MAC |
| phy_txd_o | output | 4 | Gated transmit data to the core |
| phy_txen_o | output | 1 | Gated transmit enable to the core |
| phy_txer_o | output | 1 | Gated transmit error to the core |
| phy_rxd_i | input | 4 | Receive data from the core |
| phy_rxdv_i | input | 1 | Receive data valid from the core |
| phy_rxer_i | input | 1 | Receive error from the core |
| mac_rxd_o | output | 4 | Receive data to the MAC pins |
| mac_rxdv_o | output | 1 | Receive valid to the MAC pins |
| mac_rxer_o | output | 1 | Receive error to the MAC pins |
| mac_oe_o | output | 1 | Output enable of MAC-side pins |

## Verification
Every bit of state is visible on `rd_data` in the cycle after the edge that sets it, so a wrong field value shows up at the very next read. A wrong restart state shows two ways: bit 9 stays stuck at 1 after an acknowledge, or `an_start` is missing or repeated, one cycle after the triggering write. A low-power edge detector that is out of step shows as a `latch_clr` pulse outside the cycle in which `lowpwr_o` rises. Gating faults show at once on the combinational MAC-side outputs, so the bench drives fresh random pin values with every register state.

// File: rtl/phy_ctrl_pkg.sv
package phy_ctrl_pkg;
    localparam int REG_W   = 16;
    localparam int B_ANEN  = 12;
    localparam int B_LP    = 11;
    localparam int B_ISO   = 10;
    localparam int B_RST   = 9;
    localparam logic [REG_W-1:0] RSV_MASK = ~((16'h1) << B_ANEN | (16'h1) << B_LP |
                                              (16'h1) << B_ISO  | (16'h1) << B_RST);

    typedef enum logic [1:0] {
        AN_IDLE = 2'd0,
        AN_REQ  = 2'd1,
        AN_WAIT = 2'd2
    } an_state_t;

    typedef struct packed {
        logic anen;
        logic lp;
        logic iso;
    } ctrl_fields_t;
endpackage

// File: rtl/phy_ctrl_fields.sv
module phy_ctrl_fields
    import phy_ctrl_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output ctrl_fields_t      fields,
    output logic              lp_rise
);
    ctrl_fields_t fld_q;
    logic         lp_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fld_q.anen <= 1'b1;
            fld_q.lp   <= 1'b0;
            fld_q.iso  <= (phy_addr == '0);
        end else if (wr_en) begin
            fld_q.anen <= wr_data[B_ANEN];
            fld_q.lp   <= wr_data[B_LP];
            fld_q.iso  <= wr_data[B_ISO];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lp_prev_q <= 1'b0;
        end else begin
            lp_prev_q <= fld_q.lp;
        end
    end

    always_comb begin
        fields  = fld_q;
        lp_rise = fld_q.lp & ~lp_prev_q;
    end
endmodule

// File: rtl/phy_an_restart.sv
module phy_an_restart
    import phy_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic cancel,
    input  logic ack,
    output logic start,
    output logic pending
);
    an_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            AN_IDLE: if (req)          state_d = AN_REQ;
            AN_REQ:  if (ack || cancel) state_d = AN_IDLE;
                     else               state_d = AN_WAIT;
            AN_WAIT: if (ack || cancel) state_d = AN_IDLE;
            default:                    state_d = AN_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= AN_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        start   = 1'b0;
        pending = 1'b0;
        unique case (state_q)
            AN_IDLE: ;
            AN_REQ:  begin start = 1'b1; pending = 1'b1; end
            AN_WAIT: pending = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/phy_mac_gate.sv
module phy_mac_gate #(
    parameter int MII_W = 4
) (
    input  logic             iso,
    input  logic             lp,
    input  logic [MII_W-1:0] mac_txd_i,
    input  logic             mac_txen_i,
    input  logic             mac_txer_i,
    output logic [MII_W-1:0] phy_txd_o,
    output logic             phy_txen_o,
    output logic             phy_txer_o,
    input  logic [MII_W-1:0] phy_rxd_i,
    input  logic             phy_rxdv_i,
    input  logic             phy_rxer_i,
    output logic [MII_W-1:0] mac_rxd_o,
    output logic             mac_rxdv_o,
    output logic             mac_rxer_o,
    output logic             mac_oe_o,
    output logic             tp_tx_tristate
);
    logic tx_block;
    assign tx_block = iso | lp;

    for (genvar i = 0; i < MII_W; i++) begin : g_lane
        assign phy_txd_o[i] = mac_txd_i[i] & ~tx_block;
        assign mac_rxd_o[i] = phy_rxd_i[i] & ~lp;
    end

    assign phy_txen_o     = mac_txen_i & ~tx_block;
    assign phy_txer_o     = mac_txer_i & ~tx_block;
    assign mac_rxdv_o     = phy_rxdv_i & ~lp;
    assign mac_rxer_o     = phy_rxer_i & ~lp;
    assign mac_oe_o       = ~iso;
    assign tp_tx_tristate = lp;
endmodule

// File: rtl/phy_ctrl_reg.sv
module phy_ctrl_reg
    import phy_ctrl_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int MII_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic              wr_en,
    input  logic [15:0]       wr_data,
    output logic [15:0]       rd_data,
    output logic              an_start,
    input  logic              an_started,
    output logic              isolate_o,
    output logic              lowpwr_o,
    output logic              tp_tx_tristate,
    output logic              latch_clr,
    input  logic [MII_W-1:0]  mac_txd_i,
    input  logic              mac_txen_i,
    input  logic              mac_txer_i,
    output logic [MII_W-1:0]  phy_txd_o,
    output logic              phy_txen_o,
    output logic              phy_txer_o,
    input  logic [MII_W-1:0]  phy_rxd_i,
    input  logic              phy_rxdv_i,
    input  logic              phy_rxer_i,
    output logic [MII_W-1:0]  mac_rxd_o,
    output logic              mac_rxdv_o,
    output logic              mac_rxer_o,
    output logic              mac_oe_o
);
    ctrl_fields_t fields;
    logic         lp_rise;
    logic         an_req, an_cancel, an_pending;

    phy_ctrl_fields #(.ADDR_W(ADDR_W)) u_fields (
        .clk      (clk),
        .rst_n    (rst_n),
        .phy_addr (phy_addr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .fields   (fields),
        .lp_rise  (lp_rise)
    );

    // A restart request needs negotiation enabled by the same write.
    assign an_req    = wr_en & wr_data[B_RST] & wr_data[B_ANEN];
    assign an_cancel = wr_en & ~wr_data[B_ANEN];

    phy_an_restart u_an (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (an_req),
        .cancel  (an_cancel),
        .ack     (an_started),
        .start   (an_start),
        .pending (an_pending)
    );

    phy_mac_gate #(.MII_W(MII_W)) u_gate (
        .iso            (fields.iso),
        .lp             (fields.lp),
        .mac_txd_i      (mac_txd_i),
        .mac_txen_i     (mac_txen_i),
        .mac_txer_i     (mac_txer_i),
        .phy_txd_o      (phy_txd_o),
        .phy_txen_o     (phy_txen_o),
        .phy_txer_o     (phy_txer_o),
        .phy_rxd_i      (phy_rxd_i),
        .phy_rxdv_i     (phy_rxdv_i),
        .phy_rxer_i     (phy_rxer_i),
        .mac_rxd_o      (mac_rxd_o),
        .mac_rxdv_o     (mac_rxdv_o),
        .mac_rxer_o     (mac_rxer_o),
        .mac_oe_o       (mac_oe_o),
        .tp_tx_tristate (tp_tx_tristate)
    );

    always_comb begin
        rd_data         = '0;
        rd_data[B_ANEN] = fields.anen;
        rd_data[B_LP]   = fields.lp;
        rd_data[B_ISO]  = fields.iso;
        rd_data[B_RST]  = an_pending;
    end

    assign isolate_o = fields.iso;
    assign lowpwr_o  = fields.lp;
    assign latch_clr = lp_rise;
endmodule

// File: rtl/phy_ctrl_chk.sv
module phy_ctrl_chk #(
    parameter int MII_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [15:0]      wr_data,
    input logic [15:0]      rd_data,
    input logic             an_start,
    input logic             an_started,
    input logic             isolate_o,
    input logic             lowpwr_o,
    input logic             tp_tx_tristate,
    input logic             latch_clr,
    input logic [MII_W-1:0] phy_txd_o,
    input logic             phy_txen_o,
    input logic [MII_W-1:0] mac_rxd_o,
    input logic             mac_oe_o
);
    p_start_on_request_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[9] && wr_data[12] && !rd_data[9]) |=> (an_start && rd_data[9]));

    p_start_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        an_start |=> !an_start);

    p_clear_on_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[9] && an_started) |=> !rd_data[9]);

    p_gated_by_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[12]) |=> (!rd_data[9] && !an_start));

    p_clear_on_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        latch_clr |-> (lowpwr_o && !$past(lowpwr_o)));

    p_lowpower_outputs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lowpwr_o |-> (tp_tx_tristate && mac_rxd_o == '0 && phy_txd_o == '0));

    p_isolate_outputs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        isolate_o |-> (!mac_oe_o && !phy_txen_o && phy_txd_o == '0));
endmodule

bind phy_ctrl_reg phy_ctrl_chk #(.MII_W(MII_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (wr_en),
    .wr_data        (wr_data),
    .rd_data        (rd_data),
    .an_start       (an_start),
    .an_started     (an_started),
    .isolate_o      (isolate_o),
    .lowpwr_o       (lowpwr_o),
    .tp_tx_tristate (tp_tx_tristate),
    .latch_clr      (latch_clr),
    .phy_txd_o      (phy_txd_o),
    .phy_txen_o     (phy_txen_o),
    .mac_rxd_o      (mac_rxd_o),
    .mac_oe_o       (mac_oe_o)
);

// File: tb/phy_ctrl_reg_tb.sv
`timescale 1ns/1ps
module phy_ctrl_reg_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  phy_addr = 5'd0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        an_start, an_started = 1'b0;
    logic        isolate_o, lowpwr_o, tp_tx_tristate, latch_clr;
    logic [3:0]  mac_txd_i = '0, phy_txd_o, phy_rxd_i = '0, mac_rxd_o;
    logic        mac_txen_i = 0, mac_txer_i = 0, phy_txen_o, phy_txer_o;
    logic        phy_rxdv_i = 0, phy_rxer_i = 0, mac_rxdv_o, mac_rxer_o, mac_oe_o;

    int checks = 0;
    int errors = 0;
    bit m_anen, m_lp, m_iso, m_pend, m_start, m_clr;

    always #2 clk = ~clk;

    phy_ctrl_reg u_dut (
        .clk(clk), .rst_n(rst_n), .phy_addr(phy_addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .an_start(an_start),
        .an_started(an_started), .isolate_o(isolate_o), .lowpwr_o(lowpwr_o),
        .tp_tx_tristate(tp_tx_tristate), .latch_clr(latch_clr),
        .mac_txd_i(mac_txd_i), .mac_txen_i(mac_txen_i), .mac_txer_i(mac_txer_i),
        .phy_txd_o(phy_txd_o), .phy_txen_o(phy_txen_o), .phy_txer_o(phy_txer_o),
        .phy_rxd_i(phy_rxd_i), .phy_rxdv_i(phy_rxdv_i), .phy_rxer_i(phy_rxer_i),
        .mac_rxd_o(mac_rxd_o), .mac_rxdv_o(mac_rxdv_o), .mac_rxer_o(mac_rxer_o),
        .mac_oe_o(mac_oe_o)
    );

    function automatic logic [15:0] exp_rd();
        return {3'b000, m_anen, m_lp, m_iso, m_pend, 9'b0};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all();
        logic [3:0] etxd, erxd;
        bit blk;
        blk  = m_iso | m_lp;
        etxd = blk ? 4'h0 : mac_txd_i;
        erxd = m_lp ? 4'h0 : phy_rxd_i;
        chk((rd_data & 16'hE1FF) == 0, "R2", rd_data, rd_data & 16'h1E00);
        chk(rd_data[12:10] == exp_rd() >> 10, "R3", rd_data, exp_rd());
        chk({isolate_o, lowpwr_o} == {m_iso, m_lp}, "R3", {14'b0, isolate_o, lowpwr_o}, {14'b0, m_iso, m_lp});
        chk(an_start == m_start, "R4", {15'b0, an_start}, {15'b0, m_start});
        chk(rd_data[9] == m_pend, "R5", rd_data, exp_rd());
        chk(latch_clr == m_clr, "R7", {15'b0, latch_clr}, {15'b0, m_clr});
        chk({tp_tx_tristate, mac_rxd_o, mac_rxdv_o, mac_rxer_o} ==
            {m_lp, erxd, phy_rxdv_i & ~m_lp, phy_rxer_i & ~m_lp}, "R8",
            {9'b0, tp_tx_tristate, mac_rxd_o, mac_rxdv_o, mac_rxer_o},
            {9'b0, m_lp, erxd, phy_rxdv_i & ~m_lp, phy_rxer_i & ~m_lp});
        chk({mac_oe_o, phy_txd_o, phy_txen_o, phy_txer_o} ==
            {~m_iso, etxd, mac_txen_i & ~blk, mac_txer_i & ~blk}, "R9",
            {9'b0, mac_oe_o, phy_txd_o, phy_txen_o, phy_txer_o},
            {9'b0, ~m_iso, etxd, mac_txen_i & ~blk, mac_txer_i & ~blk});
    endtask

    task automatic do_reset(input logic [4:0] addr);
        @(negedge clk);
        rst_n = 1'b0; phy_addr = addr; wr_en = 0; an_started = 0;
        @(negedge clk);
        m_anen = 1; m_lp = 0; m_iso = (addr == 0); m_pend = 0; m_start = 0; m_clr = 0;
        rst_n = 1'b1;
        chk(rd_data == (addr == 0 ? 16'h1400 : 16'h1000), "R1", rd_data, addr == 0 ? 16'h1400 : 16'h1000);
        chk({isolate_o, lowpwr_o, an_start, latch_clr} == {addr == 0, 3'b000}, "R1",
            {12'b0, isolate_o, lowpwr_o, an_start, latch_clr}, {12'b0, addr == 0, 3'b000});
        check_all();
    endtask

    // Called at a negative edge; applies one clock of stimulus and checks.
    task automatic step(input bit wr, input logic [15:0] d, input bit ack);
        bit req, n_pend;
        wr_en = wr; wr_data = d; an_started = ack;
        mac_txd_i = 4'($urandom); mac_txen_i = 1'($urandom); mac_txer_i = 1'($urandom);
        phy_rxd_i = 4'($urandom); phy_rxdv_i = 1'($urandom); phy_rxer_i = 1'($urandom);
        req = !m_pend && wr && d[9] && d[12];
        if (m_pend && (ack || (wr && !d[12]))) n_pend = 0;
        else if (req) n_pend = 1;
        else n_pend = m_pend;
        m_start = req;
        m_clr   = wr && d[11] && !m_lp;
        m_pend  = n_pend;
        if (wr) begin m_anen = d[12]; m_lp = d[11]; m_iso = d[10]; end
        @(posedge clk);
        @(negedge clk);
        wr_en = 0; an_started = 0;
        check_all();
    endtask

    initial begin
        void'($urandom(32'd1893));
        do_reset(5'd0);
        do_reset(5'd5);
        // R2: every reserved bit set in a write
        step(1, 16'hFFFF, 0);
        chk(rd_data == 16'h1E00, "R2", rd_data, 16'h1E00);
        step(0, 0, 1);
        // R6: restart request with negotiation disabled
        step(1, 16'h0200, 0);
        chk(rd_data[9] == 0 && !an_start, "R6", rd_data, 16'h0000);
        step(0, 0, 0);
        chk(!an_start, "R6", {15'b0, an_start}, 16'h0);
        // R4 / R5: request, hold, acknowledge
        step(1, 16'h1200, 0);
        chk(an_start && rd_data[9], "R4", rd_data, 16'h1200);
        step(1, 16'h1200, 0);
        chk(!an_start && rd_data[9], "R5", {15'b0, an_start}, 16'h0);
        step(0, 0, 1);
        chk(rd_data == 16'h1000, "R5", rd_data, 16'h1000);
        // R6: withdrawing enable cancels a pending restart
        step(1, 16'h1200, 0);
        step(1, 16'h0000, 0);
        chk(rd_data == 16'h0000, "R6", rd_data, 16'h0000);
        // R11: entering low power keeps other fields and pending restart
        step(1, 16'h1600, 0);
        step(1, 16'h1C00, 0);
        chk(rd_data == 16'h1E00 && latch_clr, "R11", rd_data, 16'h1E00);
        step(1, 16'h1C00, 0);
        chk(!latch_clr, "R7", {15'b0, latch_clr}, 16'h0);
        // R10: register access while isolated and in low power
        step(1, 16'h1800, 1);
        chk(rd_data == 16'h1800, "R10", rd_data, 16'h1800);
        step(1, 16'h0C00, 0);
        chk(rd_data == 16'h0C00, "R10", rd_data, 16'h0C00);
        step(1, 16'h0000, 0);
        chk(rd_data == 16'h0000 && mac_oe_o, "R10", rd_data, 16'h0000);
        // Random phase
        for (int i = 0; i < 4000; i++) begin
            logic [15:0] d;
            d = 16'($urandom);
            if ($urandom_range(0, 3) != 0) d[12] = 1'b1;
            step($urandom_range(0, 2) == 0, d, $urandom_range(0, 3) == 0);
        end
        do_reset(5'd17);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule